// File: doc/BRIEF.md
# Shared Row-Buffer Bank State Tracker

This block tracks which rows are open in a multi-bank memory device whose sense-amplifier row buffers are each shared by two neighbouring banks. Because a buffer serves two banks, two adjacent banks may never have open rows at the same time. A memory controller presents one proposed command per cycle: activate, read, write or precharge, with a bank index and a row address. The tracker answers in the same cycle. It says whether the command may be issued now and, for a read or write, whether the access is a row hit, a row miss or a neighbour conflict. When banks must be closed first, it gives a mask naming them.

When the controller raises the issue strobe, the tracker takes the proposed command as issued. Its per-bank open flags and row tags update at the next clock edge. Three saturating counters record how many issued accesses were hits, misses and conflicts. A single-cycle clear input zeroes all three. The bank count is a parameter, and banks are numbered so that bank i neighbours banks i-1 and i+1. Bank 0 and the last bank each have only one neighbour.

Top module: `sabt_tracker`

## Requirements
- R1: After reset every bank is closed (bank_open all zero) and all three counters read zero.
- R2: Command encoding is 2'b00 activate, 2'b01 read, 2'b10 write, 2'b11 precharge. An activate to an in-range bank b is legal only when banks b-1, b and b+1 are all closed. pre_mask has bit i set for each open bank among those three. An issued legal activate sets bank_open[b] and records the row.
- R3: There is no wrap-around at the array edges. Bank 0 has only bank 1 as a neighbour, and bank NUM_BANKS-1 has only bank NUM_BANKS-2.
- R4: For an in-range read or write, exactly one of acc_hit, acc_miss and acc_conflict is high. Conflict applies when either neighbour is open. Otherwise hit applies when the bank is open with the same row, and miss applies in every other case. All three are low for activate and precharge.
- R5: A read or write is legal only on a hit and never changes bank state. Its pre_mask holds the open neighbours, plus the bank itself when that bank is open with another row.
- R6: A precharge to an in-range bank is always legal, and its pre_mask is zero. When issued, it closes the bank. Issued to a closed bank, it leaves bank_open unchanged.
- R7: An issued illegal command leaves bank_open unchanged. A bank index of NUM_BANKS or above makes every command illegal, with no class flag and a zero mask.
- R8: Each issued access raises the counter of its class by one on the next edge. A counter at its all-ones value stays there.
- R9: cnt_clr zeroes all three counters on the next edge and takes priority over an increment in the same cycle.
- R10: Two adjacent banks are never open at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prop_cmd | input | 2 | Proposed command code |
| prop_bank | input | BANK_W | Proposed bank index |
| prop_row | input | ROW_W | Proposed row address |
| issue | input | 1 | Proposed command is issued this cycle |
| cnt_clr | input | 1 | Clear pulse for the class counters |
| cmd_ok | output | 1 | Proposed command is legal now |
| acc_hit | output | 1 | Access is a row hit |
| acc_miss | output | 1 | Access is a row miss |
| acc_conflict | output | 1 | Access blocked by an open neighbour |
| pre_mask | output | NUM_BANKS | Banks to precharge before the command can go |
| bank_open | output | NUM_BANKS | Current per-bank open flags |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |
| conflict_count | output | CNT_W | Saturating conflict counter |

## Verification
Two functions can land in the same cycle: a counter clear and the increment from an issued access. A second pairing is a state-changing issue and the legality check of the command presented with it. A pseudo-random stream drives clear pulses, with the issue strobe high most of the time, so clears coincide with hits, misses and conflicts. Some of these coincidences occur while a counter sits at its saturated value. The bench expects the clear to win. It also expects every verdict to reflect only the state before that cycle's edge, and it compares each cycle against a model built from the adjacency rules. Exhaustive sweeps over every bank index, including out-of-range ones, every command and two rows, from several fixed open patterns, cover the edge banks and the neighbour masks.

// File: rtl/sabt_pkg.sv
package sabt_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'b00,
    CMD_RD  = 2'b01,
    CMD_WR  = 2'b10,
    CMD_PRE = 2'b11
  } sabt_cmd_e;

  // class flags of an access, one bit per counter
  typedef struct packed {
    logic conflict;
    logic miss;
    logic hit;
  } sabt_class_t;

  localparam int NUM_CLASSES = 3;

endpackage

// File: rtl/sabt_state.sv
module sabt_state #(
  parameter int NUM_BANKS = 16,
  parameter int ROW_W     = 14,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             upd_en,
  input  logic                             upd_open,
  input  logic [BANK_W-1:0]                upd_bank,
  input  logic [ROW_W-1:0]                 upd_row,
  output logic [NUM_BANKS-1:0]             open_o,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]  rows_o
);

  logic [NUM_BANKS-1:0] sel_vec;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic             open_q, open_d;
    logic [ROW_W-1:0] row_q, row_d;
    logic             bank_en;

    assign sel_vec[g] = (upd_bank == BANK_W'(g));
    assign bank_en    = upd_en && sel_vec[g];

    always_comb begin
      open_d = open_q;
      row_d  = row_q;
      if (bank_en) begin
        open_d = upd_open;
        if (upd_open) row_d = upd_row;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else if (bank_en) begin
        open_q <= open_d;
        row_q  <= row_d;
      end
    end

    assign open_o[g] = open_q;
    assign rows_o[g] = row_q;
  end

  logic adj_clash;
  assign adj_clash = |(open_o & (open_o >> 1));

  // R10: neighbouring banks never open together
  p_no_adjacent_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !adj_clash);

  // R6: closing an already closed bank is a no-op
  p_pre_closed_noop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_open && !(|(sel_vec & open_o))) |=> $stable(open_o));

endmodule

// File: rtl/sabt_check.sv
module sabt_check
  import sabt_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int ROW_W     = 14,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [1:0]                       cmd,
  input  logic [BANK_W-1:0]                bank,
  input  logic [ROW_W-1:0]                 row,
  input  logic [NUM_BANKS-1:0]             open_i,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0]  rows_i,
  output logic                             in_range,
  output logic                             ok,
  output sabt_class_t                      cls,
  output logic [NUM_BANKS-1:0]             mask
);

  localparam logic [BANK_W:0] BANK_LIMIT = (BANK_W+1)'(NUM_BANKS);

  logic [NUM_BANKS-1:0] own_sel, nbr_sel;
  logic [ROW_W-1:0]     own_row;
  logic                 own_open, nbr_open, row_match;

  assign in_range = ({1'b0, bank} < BANK_LIMIT);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_sel
    logic left_of, right_of;
    if (g > 0) begin : g_has_lo
      assign right_of = (bank == BANK_W'(g - 1));
    end else begin : g_no_lo
      assign right_of = 1'b0;
    end
    if (g < NUM_BANKS - 1) begin : g_has_hi
      assign left_of = (bank == BANK_W'(g + 1));
    end else begin : g_no_hi
      assign left_of = 1'b0;
    end
    assign own_sel[g] = in_range && (bank == BANK_W'(g));
    assign nbr_sel[g] = in_range && (left_of || right_of);
  end

  always_comb begin
    own_row = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (own_sel[i]) own_row = own_row | rows_i[i];
    end
  end

  assign own_open  = |(own_sel & open_i);
  assign nbr_open  = |(nbr_sel & open_i);
  assign row_match = (own_row == row);

  always_comb begin
    ok   = 1'b0;
    cls  = '0;
    mask = '0;
    if (in_range) begin
      unique case (sabt_cmd_e'(cmd))
        CMD_ACT: begin
          ok   = !nbr_open && !own_open;
          mask = (nbr_sel | own_sel) & open_i;
        end
        CMD_RD, CMD_WR: begin
          cls.conflict = nbr_open;
          cls.hit      = !nbr_open && own_open && row_match;
          cls.miss     = !nbr_open && !(own_open && row_match);
          ok           = cls.hit;
          mask         = (nbr_sel & open_i) |
                         (own_sel & open_i & {NUM_BANKS{!row_match}});
        end
        CMD_PRE: begin
          ok = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sabt_satcnt.sv
module sabt_satcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clr || inc;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                   cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && count == CNT_MAX) |=> (count == CNT_MAX));

  p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && count != CNT_MAX) |=> (count == $past(count) + CNT_W'(1)));

  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

endmodule

// File: rtl/sabt_tracker.sv
module sabt_tracker
  import sabt_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int ROW_W     = 14,
  parameter int CNT_W     = 16,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           prop_cmd,
  input  logic [BANK_W-1:0]    prop_bank,
  input  logic [ROW_W-1:0]     prop_row,
  input  logic                 issue,
  input  logic                 cnt_clr,
  output logic                 cmd_ok,
  output logic                 acc_hit,
  output logic                 acc_miss,
  output logic                 acc_conflict,
  output logic [NUM_BANKS-1:0] pre_mask,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [CNT_W-1:0]     hit_count,
  output logic [CNT_W-1:0]     miss_count,
  output logic [CNT_W-1:0]     conflict_count
);

  logic [NUM_BANKS-1:0][ROW_W-1:0] row_tags;
  logic                            in_range;
  sabt_class_t                     cls;
  logic                            is_access, upd_en, upd_open;

  assign is_access = (prop_cmd == CMD_RD) || (prop_cmd == CMD_WR);
  assign upd_en    = issue && cmd_ok && !is_access;
  assign upd_open  = (prop_cmd == CMD_ACT);

  sabt_state #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (upd_en),
    .upd_open (upd_open),
    .upd_bank (prop_bank),
    .upd_row  (prop_row),
    .open_o   (bank_open),
    .rows_o   (row_tags)
  );

  sabt_check #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_check (
    .cmd      (prop_cmd),
    .bank     (prop_bank),
    .row      (prop_row),
    .open_i   (bank_open),
    .rows_i   (row_tags),
    .in_range (in_range),
    .ok       (cmd_ok),
    .cls      (cls),
    .mask     (pre_mask)
  );

  assign acc_hit      = cls.hit;
  assign acc_miss     = cls.miss;
  assign acc_conflict = cls.conflict;

  logic [NUM_CLASSES-1:0]            inc_vec;
  logic [NUM_CLASSES-1:0][CNT_W-1:0] cnt_vec;

  assign inc_vec = {NUM_CLASSES{issue}} & cls;

  for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_cnt
    sabt_satcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (inc_vec[g]),
      .count (cnt_vec[g])
    );
  end

  assign hit_count      = cnt_vec[0];
  assign miss_count     = cnt_vec[1];
  assign conflict_count = cnt_vec[2];

  logic [NUM_BANKS-1:0] bank_oh;
  assign bank_oh = NUM_BANKS'(1) << prop_bank;

  p_class_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_range && is_access) |-> $onehot({acc_hit, acc_miss, acc_conflict}));

  p_no_class_other_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !is_access |-> !(acc_hit || acc_miss || acc_conflict));

  p_act_clear_nbrs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prop_cmd == CMD_ACT && cmd_ok) |-> (pre_mask == '0));

  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && cmd_ok && prop_cmd == CMD_ACT) |=> ((bank_open & $past(bank_oh)) != '0));

  p_illegal_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !cmd_ok) |=> $stable(bank_open));

  p_pre_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && cmd_ok && prop_cmd == CMD_PRE) |=> ((bank_open & $past(bank_oh)) == '0));

endmodule

// File: tb/sabt_tracker_tb.sv
module sabt_tracker_tb;

  localparam int NB = 6;
  localparam int RW = 3;
  localparam int CW = 4;
  localparam int BW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    prop_cmd;
  logic [BW-1:0] prop_bank;
  logic [RW-1:0] prop_row;
  logic          issue, cnt_clr;
  logic          cmd_ok, acc_hit, acc_miss, acc_conflict;
  logic [NB-1:0] pre_mask, bank_open;
  logic [CW-1:0] hit_count, miss_count, conflict_count;

  always #10 clk = ~clk;

  sabt_tracker #(.NUM_BANKS(NB), .ROW_W(RW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .prop_cmd(prop_cmd), .prop_bank(prop_bank),
    .prop_row(prop_row), .issue(issue), .cnt_clr(cnt_clr), .cmd_ok(cmd_ok),
    .acc_hit(acc_hit), .acc_miss(acc_miss), .acc_conflict(acc_conflict),
    .pre_mask(pre_mask), .bank_open(bank_open), .hit_count(hit_count),
    .miss_count(miss_count), .conflict_count(conflict_count)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  bit          m_open [NB];
  int          m_row  [NB];
  int          m_cnt  [3];

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive after the falling edge, judge before the rising edge, update model at it
  task automatic step(int cmd, int bank, int row, bit iss, bit clr, string tag);
    bit ok_e, hit_e, miss_e, conf_e, nb, acc;
    int mask_e, open_e, d;
    string rq;
    @(negedge clk);
    prop_cmd = 2'(cmd); prop_bank = BW'(bank); prop_row = RW'(row);
    issue = iss; cnt_clr = clr;
    #5;
    ok_e = 0; hit_e = 0; miss_e = 0; conf_e = 0; mask_e = 0; nb = 0;
    acc = (cmd == 1) || (cmd == 2);
    if (bank < NB) begin
      for (int j = 0; j < NB; j++) begin
        d = j - bank;
        if ((d == 1 || d == -1) && m_open[j]) nb = 1;
      end
      for (int j = 0; j < NB; j++) begin
        d = j - bank;
        if (cmd == 0 && d >= -1 && d <= 1 && m_open[j]) mask_e |= (1 << j);
        if (acc && (d == 1 || d == -1) && m_open[j]) mask_e |= (1 << j);
        if (acc && d == 0 && m_open[j] && m_row[j] != row) mask_e |= (1 << j);
      end
      if (cmd == 0) ok_e = !nb && !m_open[bank];
      else if (cmd == 3) ok_e = 1;
      else begin
        conf_e = nb;
        hit_e  = !nb && m_open[bank] && m_row[bank] == row;
        miss_e = !nb && !hit_e;
        ok_e   = hit_e;
      end
    end
    open_e = 0;
    for (int j = 0; j < NB; j++) if (m_open[j]) open_e |= (1 << j);
    if (tag != "") rq = tag;
    else if (bank >= NB) rq = "R7";
    else if (cmd == 0) rq = "R2";
    else if (cmd == 3) rq = "R6";
    else rq = "R5";
    chk(rq, "cmd_ok", int'(cmd_ok), int'(ok_e));
    chk(rq, "pre_mask", int'(pre_mask), mask_e);
    chk("R4", "class", int'({acc_conflict, acc_miss, acc_hit}), int'({conf_e, miss_e, hit_e}));
    chk("R7 R10", "bank_open", int'(bank_open), open_e);
    chk("R8 R9", "hit_count", int'(hit_count), m_cnt[0]);
    chk("R8 R9", "miss_count", int'(miss_count), m_cnt[1]);
    chk("R8 R9", "conflict_count", int'(conflict_count), m_cnt[2]);
    @(posedge clk);
    if (iss && ok_e && cmd == 0) begin m_open[bank] = 1; m_row[bank] = row; end
    if (iss && ok_e && cmd == 3) m_open[bank] = 0;
    if (clr) for (int k = 0; k < 3; k++) m_cnt[k] = 0;
    else if (iss) begin
      if (hit_e  && m_cnt[0] < CMAX) m_cnt[0]++;
      if (miss_e && m_cnt[1] < CMAX) m_cnt[1]++;
      if (conf_e && m_cnt[2] < CMAX) m_cnt[2]++;
    end
  endtask

  task automatic sweep();
    for (int b = 0; b < 8; b++)
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 2; r++)
          step(c, b, r, 1'b0, 1'b0, "");
  endtask

  initial begin
    logic [15:0] lfsr;
    rst_n = 0; prop_cmd = 0; prop_bank = 0; prop_row = 0; issue = 0; cnt_clr = 0;
    for (int j = 0; j < NB; j++) begin m_open[j] = 0; m_row[j] = 0; end
    for (int k = 0; k < 3; k++) m_cnt[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset state
    step(3, 0, 0, 1'b0, 1'b0, "R1");
    sweep();
    // R3: edge banks; bank 0 open blocks bank 1 only
    step(0, 0, 1, 1'b1, 1'b0, "R3");
    step(0, 1, 0, 1'b1, 1'b0, "R3");
    step(0, 3, 0, 1'b1, 1'b0, "R3");
    sweep();
    step(0, 5, 2, 1'b1, 1'b0, "R3");
    step(0, 4, 2, 1'b1, 1'b0, "R3");
    step(1, 5, 2, 1'b1, 1'b0, "R3");
    step(2, 4, 2, 1'b1, 1'b0, "R3");
    sweep();
    // R6: precharge of a closed bank, then of open banks
    step(3, 2, 0, 1'b1, 1'b0, "R6");
    step(3, 0, 0, 1'b1, 1'b0, "R6");
    step(3, 3, 0, 1'b1, 1'b0, "R6");
    step(3, 5, 0, 1'b1, 1'b0, "R6");
    // R8 R9: pseudo-random traffic with saturation and coinciding clears
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(int'(lfsr[1:0]), int'(lfsr[4:2]), int'(lfsr[5]),
           lfsr[8] | lfsr[9] | lfsr[10], (lfsr[15:10] == 6'd0), "");
    end
    step(1, 0, 0, 1'b1, 1'b1, "R9");
    step(1, 0, 0, 1'b0, 1'b0, "R9");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule